// File: doc/BRIEF.md
# Rate-Selectable Tick Timer with Interrupt Controller

This block makes a periodic timer tick and merges it with two DMA completion events into one interrupt line. A prescaler turns the system clock into a 37.5 kHz base tick. A 3-bit rate code then divides that base by one of eight nonuniform factors. Each tick, and each completion pulse from the SD DMA engine or the MP3 DMA engine, sets its own pending bit. The interrupt output is high while any pending bit has its enable bit set.

Software reaches three registers through a single write port and a combinational read port: the rate code, the enable mask and the request mask. The two masks do not take a plain load. Bit 7 of the written byte picks set or clear, and the low bits pick which sources change. One field can therefore change without reading the register first. Writing the rate code restarts the tick period from zero. The prescaler divide value is a parameter, chosen from the system clock frequency.

Top module: `tick_irq_ctrl`

## Requirements
- R1: After reset, the rate code, the enable mask and the request mask read as zero, and `irq_o` is low.
- R2: While the rate code holds value c, `tick_o` pulses high for one cycle every PRE_DIV*D(c) clock cycles. D is 1, 2, 4, 8, 16, 64, 256, 1024 for c = 0..7.
- R3: A write to the rate register restarts the period. The first `tick_o` after the write comes exactly PRE_DIV*D(new code) cycles after the write edge, and no tick comes from that write edge itself.
- R4: Register select 1 is the enable mask. Bit 0 is the timer, bit 1 is SD DMA and bit 2 is MP3 DMA. A write with data bit 7 = 1 sets every mask bit whose data bit is 1. A write with bit 7 = 0 clears them. Mask bits whose data bit is 0 keep their value.
- R5: Register select 2 is the request mask. It has the same bit positions as R4 and the same set/clear write rule.
- R6: A pulse on `sd_done_i` or `mp3_done_i`, or a timer tick, sets request bit 1, 2 or 0, whether or not that source is enabled. The timer bit is set at the same edge where `tick_o` rises.
- R7: `irq_o` is high exactly while (request AND enable) is nonzero. It follows register changes in the cycle after the edge that caused them.
- R8: When a source event and a software clear hit the same request bit at the same edge, the bit ends up set.
- R9: `rd_data_o` is combinational from `rd_sel_i`. Select 0 returns the rate code in bits 2:0, select 1 the enable mask, select 2 the request mask and select 3 zero. Bits 7:3 are always zero.
- R10: Data bits 6:3 of a mask write have no effect. Select 0 takes only data bits 2:0. A write with select 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 rate, 1 enable, 2 request, 3 none |
| wr_data_i | input | 8 | Write data; bit 7 is set/clear for the masks |
| rd_sel_i | input | 2 | Read target, same encoding as wr_sel_i |
| rd_data_o | output | 8 | Read data of the selected register |
| sd_done_i | input | 1 | One-cycle SD DMA completion pulse |
| mp3_done_i | input | 1 | One-cycle MP3 DMA completion pulse |
| tick_o | output | 1 | One-cycle timer tick |
| irq_o | output | 1 | Interrupt request |

## Verification
Register writes and source pulses take effect at the first clock edge that samples them. Read data and `irq_o` reflect the new state in the cycle right after that edge, and `tick_o` rises at its period edge together with request bit 0. The bench drives inputs on falling edges and updates its reference state at each rising edge. It compares all three outputs a quarter period after the rising edge, when only that edge's effects can be visible. Tick spacing after a rate write is measured by counting falling edges from the write edge, and is compared with PRE_DIV times the divisor for that code.

// File: rtl/tirq_pkg.sv
package tirq_pkg;
  localparam int DW          = 8;
  localparam int NSRC        = 3;
  localparam int SRC_TMR     = 0;
  localparam int SRC_SD      = 1;
  localparam int SRC_MP3     = 2;
  localparam int RATE_W      = 3;
  localparam int SHIFT_W     = 4;
  localparam int MAX_SHIFT   = 10;
  localparam int OP_BIT      = 7;

  typedef enum logic [1:0] {
    SEL_RATE = 2'd0,
    SEL_EN   = 2'd1,
    SEL_REQ  = 2'd2,
    SEL_NONE = 2'd3
  } sel_e;

  // divisor is a power of two; table is nonuniform above code 4
  function automatic logic [SHIFT_W-1:0] rate_shift(input logic [RATE_W-1:0] code);
    case (code)
      3'd5:    rate_shift = 4'd6;
      3'd6:    rate_shift = 4'd8;
      3'd7:    rate_shift = 4'd10;
      default: rate_shift = {1'b0, code};
    endcase
  endfunction
endpackage

// File: rtl/tirq_prescaler.sv
module tirq_prescaler #(
  parameter int PRE_DIV = 640
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic tick_o
);
  localparam int PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRE_DIV - 1);

  logic [PW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (tick_o)    cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tirq_rate_div.sv
module tirq_rate_div
  import tirq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               restart_i,
  input  logic               base_tick_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic               tick_o
);
  logic [MAX_SHIFT-1:0] cnt_q;
  logic [MAX_SHIFT:0]   span;
  logic [MAX_SHIFT-1:0] limit;
  logic                 at_limit;

  assign span     = (MAX_SHIFT+1)'(1) << shift_i;
  assign limit    = MAX_SHIFT'(span - 1'b1);
  assign at_limit = (cnt_q == limit);
  assign tick_o   = base_tick_i & at_limit & ~restart_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (restart_i)   cnt_q <= '0;
    else if (base_tick_i) cnt_q <= at_limit ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/tirq_mask_reg.sv
module tirq_mask_reg #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic         op_set_i,
  input  logic [N-1:0] bits_i,
  input  logic [N-1:0] hw_set_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] sw_val;
  logic [N-1:0] nxt;

  always_comb begin
    sw_val = op_set_i ? (q_o | bits_i) : (q_o & ~bits_i);
    // hardware set applied last so it wins over a clear
    nxt    = (wr_i ? sw_val : q_o) | hw_set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= nxt;
  end
endmodule

// File: rtl/tick_irq_ctrl.sv
module tick_irq_ctrl
  import tirq_pkg::*;
#(
  parameter int PRE_DIV = 640
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_sel_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [1:0]    rd_sel_i,
  output logic [DW-1:0] rd_data_o,
  input  logic          sd_done_i,
  input  logic          mp3_done_i,
  output logic          tick_o,
  output logic          irq_o
);
  sel_e                wsel;
  sel_e                rsel;
  logic                rate_wr;
  logic                en_wr;
  logic                req_wr;
  logic [RATE_W-1:0]   rate_q;
  logic                base_tick;
  logic                tick_now;
  logic                tick_q;
  logic [NSRC-1:0]     en_q;
  logic [NSRC-1:0]     req_q;
  logic [NSRC-1:0]     src_set;
  logic                unused_wr_bits;

  assign wsel    = sel_e'(wr_sel_i);
  assign rsel    = sel_e'(rd_sel_i);
  assign rate_wr = wr_en_i && (wsel == SEL_RATE);
  assign en_wr   = wr_en_i && (wsel == SEL_EN);
  assign req_wr  = wr_en_i && (wsel == SEL_REQ);
  assign unused_wr_bits = ^wr_data_i[OP_BIT-1:RATE_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rate_q <= '0;
    else if (rate_wr) rate_q <= wr_data_i[RATE_W-1:0];
  end

  tirq_prescaler #(.PRE_DIV(PRE_DIV)) u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (rate_wr),
    .tick_o    (base_tick)
  );

  tirq_rate_div u_div (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .restart_i   (rate_wr),
    .base_tick_i (base_tick),
    .shift_i     (rate_shift(rate_q)),
    .tick_o      (tick_now)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick_q <= 1'b0;
    else         tick_q <= tick_now;
  end
  assign tick_o = tick_q;

  always_comb begin
    src_set          = '0;
    src_set[SRC_TMR] = tick_now;
    src_set[SRC_SD]  = sd_done_i;
    src_set[SRC_MP3] = mp3_done_i;
  end

  tirq_mask_reg #(.N(NSRC)) u_en (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (en_wr),
    .op_set_i (wr_data_i[OP_BIT]),
    .bits_i   (wr_data_i[NSRC-1:0]),
    .hw_set_i ({NSRC{1'b0}}),
    .q_o      (en_q)
  );

  tirq_mask_reg #(.N(NSRC)) u_req (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (req_wr),
    .op_set_i (wr_data_i[OP_BIT]),
    .bits_i   (wr_data_i[NSRC-1:0]),
    .hw_set_i (src_set),
    .q_o      (req_q)
  );

  assign irq_o = |(req_q & en_q);

  always_comb begin
    rd_data_o = '0;
    case (rsel)
      SEL_RATE: rd_data_o[RATE_W-1:0] = rate_q;
      SEL_EN:   rd_data_o[NSRC-1:0]   = en_q;
      SEL_REQ:  rd_data_o[NSRC-1:0]   = req_q;
      default:  rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/tirq_checker.sv
module tirq_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic [1:0] wr_sel_i,
  input logic [7:0] wr_data_i,
  input logic [7:0] rd_data_o,
  input logic       sd_done_i,
  input logic       mp3_done_i,
  input logic       tick_o,
  input logic       irq_o,
  input logic [2:0] en_q,
  input logic [2:0] req_q
);
  a_r6_sd_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sd_done_i |=> req_q[1]);

  a_r6_mp3_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mp3_done_i |=> req_q[2]);

  a_r6_tick_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> req_q[0]);

  a_r7_no_en_no_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == 3'b000) |-> !irq_o);

  a_r7_irq_has_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (req_q != 3'b000));

  a_r4_en_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == 2'd1 && wr_data_i[7])
      |=> ((en_q & $past(wr_data_i[2:0])) == $past(wr_data_i[2:0])));

  a_r5_req_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == 2'd2 && !wr_data_i[7] && !sd_done_i && !mp3_done_i)
      |=> ((req_q & $past(wr_data_i[2:0]) & 3'b110) == 3'b000));

  a_r9_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[7:3] == 5'b00000);
endmodule

bind tick_irq_ctrl tirq_checker u_chk (.*);

// File: tb/sim_tick_irq_ctrl.sv
module sim_tick_irq_ctrl;
  localparam int CLK_PER = 10;
  localparam int P       = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'h00;
  logic [1:0] rd_sel = 2'd0;
  logic [7:0] rd_data;
  logic       sd = 1'b0;
  logic       mp3 = 1'b0;
  logic       tick;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [2:0] m_rate = '0;
  logic [2:0] m_en   = '0;
  logic [2:0] m_req  = '0;
  bit         m_tick = 0;
  int         m_cnt  = 0;

  tick_irq_ctrl #(.PRE_DIV(P)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .rd_sel_i(rd_sel), .rd_data_o(rd_data),
    .sd_done_i(sd), .mp3_done_i(mp3), .tick_o(tick), .irq_o(irq)
  );

  always #(CLK_PER/2) clk = ~clk;

  function automatic int divisor(input logic [2:0] c);
    case (c)
      3'd0: return 1;    3'd1: return 2;   3'd2: return 4;   3'd3: return 8;
      3'd4: return 16;   3'd5: return 64;  3'd6: return 256; default: return 1024;
    endcase
  endfunction

  function automatic logic [2:0] apply(input logic [2:0] q, input logic [7:0] d);
    return d[7] ? (q | d[2:0]) : (q & ~d[2:0]);
  endfunction

  function automatic logic [7:0] exp_rd(input logic [1:0] s);
    case (s)
      2'd0:    return {5'b0, m_rate};
      2'd1:    return {5'b0, m_en};
      2'd2:    return {5'b0, m_req};
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model, one step per rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_rate = '0; m_en = '0; m_req = '0; m_tick = 0; m_cnt = 0;
    end else begin
      bit t;
      int per;
      per = P * divisor(m_rate);
      t = 0;
      if (wr_en && wr_sel == 2'd0) begin
        m_cnt = 0;
        m_rate = wr_data[2:0];
      end else begin
        m_cnt++;
        if (m_cnt == per) begin t = 1; m_cnt = 0; end
      end
      if (wr_en && wr_sel == 2'd1) m_en = apply(m_en, wr_data);
      if (wr_en && wr_sel == 2'd2) m_req = apply(m_req, wr_data);
      m_req = m_req | {mp3, sd, t};
      m_tick = t;
    end
  end

  // continuous comparison a quarter period after each rising edge
  always begin
    @(posedge clk);
    #(CLK_PER/4);
    if (rst_n && !done) begin
      check(tick == m_tick, "R2 tick", tick, m_tick);
      check(irq == |(m_en & m_req), "R7 irq", irq, |(m_en & m_req));
      check(rd_data == exp_rd(rd_sel), "R9 readback", rd_data, exp_rd(rd_sel));
    end
  end

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic look(input logic [1:0] s, input string tag);
    @(negedge clk);
    rd_sel = s;
    @(posedge clk);
    #(CLK_PER/4);
    check(rd_data == exp_rd(s), tag, rd_data, exp_rd(s));
  endtask

  initial begin
    #(CLK_PER * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d5e));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state, read before the first tick
    look(2'd0, "R1 rate");
    check(rd_data == 8'h00, "R1 rate literal", rd_data, 0);
    look(2'd1, "R1 enable");
    look(2'd2, "R1 request");
    check(irq == 1'b0, "R1 irq", irq, 0);

    wr(2'd0, 8'h07);               // slow timer for directed mask tests
    wr(2'd2, 8'h01);               // drop any early timer request
    // R4: set bits 0 and 2, then clear bit 2
    wr(2'd1, 8'h85);
    look(2'd1, "R4 set");
    check(rd_data == 8'h05, "R4 set literal", rd_data, 5);
    wr(2'd1, 8'h04);
    look(2'd1, "R4 clear");
    check(rd_data == 8'h01, "R4 clear literal", rd_data, 1);
    // R10: bits 6:3 ignored
    wr(2'd1, 8'hFA);
    look(2'd1, "R10 upper bits");
    check(rd_data == 8'h03, "R10 literal", rd_data, 3);
    wr(2'd3, 8'h87);
    look(2'd1, "R10 sel3 write");
    look(2'd3, "R10 sel3 read");
    // R5: request set and clear
    wr(2'd2, 8'h86);
    look(2'd2, "R5 set");
    wr(2'd2, 8'h06);
    look(2'd2, "R5 clear");
    // R6: source pulse with its enable off
    wr(2'd1, 8'h04);
    @(negedge clk); mp3 = 1'b1;
    @(negedge clk); mp3 = 1'b0;
    look(2'd2, "R6 mp3 pending");
    check(irq == 1'b0, "R6 disabled no irq", irq, 0);
    // R8: sd pulse and software clear of bit 1 together
    @(negedge clk); wr_en = 1'b1; wr_sel = 2'd2; wr_data = 8'h02; sd = 1'b1;
    @(negedge clk); wr_en = 1'b0; sd = 1'b0;
    look(2'd2, "R8 set wins");
    check(rd_data[1] == 1'b1, "R8 literal", rd_data[1], 1);

    // R3: period after a rate write
    for (int c = 0; c < 8; c++) begin
      int m;
      wr(2'd0, 8'(c));
      m = 0;
      while (m < 5000) begin
        @(negedge clk);
        m++;
        if (tick) break;
      end
      check(m == P * divisor(3'(c)), "R3 first tick", m, P * divisor(3'(c)));
    end

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      wr_en   = ($urandom_range(0, 9) < 3);
      wr_sel  = 2'($urandom_range(0, 3));
      wr_data = 8'($urandom);
      if (wr_sel == 2'd0) wr_data[2] = 1'b0;
      sd      = ($urandom_range(0, 9) == 0);
      mp3     = ($urandom_range(0, 9) == 0);
      rd_sel  = 2'($urandom_range(0, 3));
    end
    @(negedge clk);
    wr_en = 1'b0; sd = 1'b0; mp3 = 1'b0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule